// File: doc/BRIEF.md
# Three-Axis Mesh Route Computation Unit

This block chooses the output direction for a flit arriving at one router of a three-dimensional mesh network-on-chip. It receives the router's own X, Y and Z position and an incoming flit. When the flit is a header, the block compares the destination carried in the header with the local position, one axis at a time in a fixed order. It produces a seven-way one-hot direction and writes that direction back into the header's next-port field, so that the flit leaves carrying the decision made here.

Body and tail flits of a packet carry no destination. They receive the direction latched from the most recent header, which keeps a wormhole packet on one path. A destination that lies outside the configured mesh is sent to the local port and flagged on an error output. By default the result is registered, so it appears one cycle after the flit is presented. A parameter selects a purely combinational result instead.

Top module: `mesh_route_unit`

## Requirements
- R1: The X axis is resolved first: if the current X is below the destination X the direction is EAST (0000100); if it is above, WEST (0001000).
- R2: Only when X matches is Y compared: a current Y below the destination Y gives NORTH (0000010); above gives SOUTH (0010000).
- R3: Only when X and Y both match is Z compared: a current Z below the destination Z gives UP (0100000); above gives DOWN (1000000).
- R4: When all three coordinates match, the direction is LOCAL (0000001). Every routed header yields exactly one set bit.
- R5: The flit is 33 bits. Bit 32 marks a header. Bits 31:29 hold the destination X, 28:26 the destination Y, 25:23 the destination Z, 22:16 the next-port field and 15:0 the payload. For a header, the output flit equals the input flit except that bits 22:16 are replaced by the chosen direction.
- R6: A valid flit with bit 32 clear is a body flit. Its direction is the one latched from the most recent valid header, its flit passes unchanged and the error output stays low.
- R7: A header whose destination X is at least MESH_X (2), whose destination Y is at least MESH_Y (2), or whose destination Z is at least MESH_Z (4) is routed LOCAL with out_err high.
- R8: With the default REG_OUT=1, the results appear on the clock edge after in_valid is sampled. When in_valid is low the next output is invalid, and whatever is on in_flit leaves the latched direction untouched.
- R9: After reset, out_valid, out_port and out_err are 0 and the latched direction is 0000000, so a body flit that arrives before any header gets 0000000.
- R10: Routing hop by hop from any node to any destination inside the mesh reaches the destination in exactly the Manhattan distance. All X moves come before any Y move, and all Y moves come before any Z move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A flit is presented this cycle |
| in_flit | input | 33 | Incoming flit |
| cur_x | input | 3 | This router's X position |
| cur_y | input | 3 | This router's Y position |
| cur_z | input | 3 | This router's Z position |
| out_valid | output | 1 | Output flit and direction are valid |
| out_flit | output | 33 | Flit with the next-port field rewritten for headers |
| out_port | output | 7 | One-hot output direction |
| out_err | output | 1 | Header destination lies outside the mesh |

## Verification
A wrong axis priority or a swapped comparison shows on out_port and on bits 22:16 of out_flit one cycle after the offending header. The hop-by-hop walk then turns the same fault into a wrong hop count or a dimension-order violation. A corrupted latched direction stays hidden until the next body flit, and then appears on out_port in that flit's output cycle. That is why the bench places body flits after headers and after idle cycles that carry stray header data. A broken range check shows up as a non-LOCAL direction or a low out_err on the cycle after a header that targets a node outside the mesh.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
    localparam int PORT_W = 7;
    typedef logic [PORT_W-1:0] port_t;

    localparam port_t DIR_LOCAL = 7'b0000001;
    localparam port_t DIR_NORTH = 7'b0000010;
    localparam port_t DIR_EAST  = 7'b0000100;
    localparam port_t DIR_WEST  = 7'b0001000;
    localparam port_t DIR_SOUTH = 7'b0010000;
    localparam port_t DIR_UP    = 7'b0100000;
    localparam port_t DIR_DOWN  = 7'b1000000;

    localparam int N_AXES = 3;
endpackage

// File: rtl/mrt_axis_cmp.sv
module mrt_axis_cmp #(
    parameter int W      = 3,
    parameter int EXTENT = 2
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] dst,
    output logic         lt,
    output logic         eq,
    output logic         oob
);
    localparam logic [W:0] LIMIT = (W+1)'(EXTENT);

    always_comb begin
        lt  = cur < dst;
        eq  = cur == dst;
        oob = {1'b0, dst} >= LIMIT;
    end
endmodule

// File: rtl/mrt_route_core.sv
module mrt_route_core
    import mrt_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int MESH_X  = 2,
    parameter int MESH_Y  = 2,
    parameter int MESH_Z  = 4
) (
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] cur_z,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [COORD_W-1:0] dst_z,
    output port_t              port,
    output logic               err
);
    localparam int    EXT     [N_AXES] = '{MESH_X, MESH_Y, MESH_Z};
    localparam port_t POS_DIR [N_AXES] = '{DIR_EAST, DIR_NORTH, DIR_UP};
    localparam port_t NEG_DIR [N_AXES] = '{DIR_WEST, DIR_SOUTH, DIR_DOWN};

    logic [COORD_W-1:0] cur_a [N_AXES];
    logic [COORD_W-1:0] dst_a [N_AXES];
    logic [N_AXES-1:0]  lt_a, eq_a, oob_a;

    assign cur_a[0] = cur_x;
    assign cur_a[1] = cur_y;
    assign cur_a[2] = cur_z;
    assign dst_a[0] = dst_x;
    assign dst_a[1] = dst_y;
    assign dst_a[2] = dst_z;

    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        mrt_axis_cmp #(.W(COORD_W), .EXTENT(EXT[a])) u_cmp (
            .cur (cur_a[a]),
            .dst (dst_a[a]),
            .lt  (lt_a[a]),
            .eq  (eq_a[a]),
            .oob (oob_a[a])
        );
    end

    always_comb begin
        logic found;
        found = 1'b0;
        port  = DIR_LOCAL;
        err   = |oob_a;
        if (!err) begin
            for (int a = 0; a < N_AXES; a++) begin
                if (!found && !eq_a[a]) begin
                    port  = lt_a[a] ? POS_DIR[a] : NEG_DIR[a];
                    found = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
    import mrt_pkg::*;
#(
    parameter int COORD_W   = 3,
    parameter int MESH_X    = 2,
    parameter int MESH_Y    = 2,
    parameter int MESH_Z    = 4,
    parameter int PAYLOAD_W = 16,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    input  logic [PAYLOAD_W+PORT_W+3*COORD_W:0]    in_flit,
    input  logic [COORD_W-1:0]                     cur_x,
    input  logic [COORD_W-1:0]                     cur_y,
    input  logic [COORD_W-1:0]                     cur_z,
    output logic                                   out_valid,
    output logic [PAYLOAD_W+PORT_W+3*COORD_W:0]    out_flit,
    output logic [PORT_W-1:0]                      out_port,
    output logic                                   out_err
);
    localparam int PORT_LO = PAYLOAD_W;
    localparam int DZ_LO   = PORT_LO + PORT_W;
    localparam int DY_LO   = DZ_LO + COORD_W;
    localparam int DX_LO   = DY_LO + COORD_W;
    localparam int MARK    = DX_LO + COORD_W;
    localparam int FLIT_W  = MARK + 1;

    typedef struct packed {
        logic              valid;
        logic [FLIT_W-1:0] flit;
        port_t             port;
        logic              err;
        port_t             hold;
    } state_t;

    state_t st_d, st_q;
    port_t  rt_port;
    logic   rt_err;

    mrt_route_core #(
        .COORD_W (COORD_W),
        .MESH_X  (MESH_X),
        .MESH_Y  (MESH_Y),
        .MESH_Z  (MESH_Z)
    ) u_core (
        .cur_x (cur_x),
        .cur_y (cur_y),
        .cur_z (cur_z),
        .dst_x (in_flit[DX_LO +: COORD_W]),
        .dst_y (in_flit[DY_LO +: COORD_W]),
        .dst_z (in_flit[DZ_LO +: COORD_W]),
        .port  (rt_port),
        .err   (rt_err)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.flit  = '0;
        st_d.port  = '0;
        st_d.err   = 1'b0;
        if (in_valid) begin
            st_d.flit = in_flit;
            if (in_flit[MARK]) begin
                st_d.port                     = rt_port;
                st_d.err                      = rt_err;
                st_d.flit[PORT_LO +: PORT_W]  = rt_port;
                st_d.hold                     = rt_port;
            end else begin
                st_d.port = st_q.hold;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    if (REG_OUT) begin : g_reg
        assign out_valid = st_q.valid;
        assign out_flit  = st_q.flit;
        assign out_port  = st_q.port;
        assign out_err   = st_q.err;

        // R8
        idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);

        // R6
        body_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_flit[MARK]) |-> (out_flit == $past(in_flit) && !out_err));

        // R1
        x_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_flit[MARK] && !out_err &&
             out_flit[DX_LO +: COORD_W] != $past(cur_x))
            |-> (out_port == DIR_EAST || out_port == DIR_WEST));

        // R5
        payload_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_flit[PORT_LO-1:0] == $past(in_flit[PORT_LO-1:0]));
    end else begin : g_comb
        assign out_valid = st_d.valid;
        assign out_flit  = st_d.flit;
        assign out_port  = st_d.port;
        assign out_err   = st_d.err;
    end

    // R4
    port_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flit[MARK]) |-> $countones(out_port) == 1);

    // R5
    field_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flit[MARK]) |-> out_flit[PORT_LO +: PORT_W] == out_port);

    // R7
    err_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_valid && out_port == DIR_LOCAL));
endmodule

// File: tb/mesh_route_unit_test.sv
`timescale 1ns/1ps
module mesh_route_unit_test;
    localparam logic [6:0] P_LOC = 7'b0000001, P_N = 7'b0000010, P_E = 7'b0000100,
                           P_W = 7'b0001000, P_S = 7'b0010000, P_U = 7'b0100000,
                           P_D = 7'b1000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [32:0] in_flit = '0;
    logic [2:0]  cur_x = '0, cur_y = '0, cur_z = '0;
    logic        out_valid, out_err;
    logic [32:0] out_flit;
    logic [6:0]  out_port;

    int checks = 0;
    int errors = 0;
    bit sb_on  = 1'b0;

    typedef struct {
        logic [6:0]  port;
        logic [32:0] flit;
        logic        err;
        string       req;
    } item_t;
    item_t sbq[$];

    always #2.5 clk = ~clk;

    mesh_route_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z),
        .out_valid(out_valid), .out_flit(out_flit), .out_port(out_port), .out_err(out_err)
    );

    function automatic logic [32:0] hdr(int dx, int dy, int dz, logic [15:0] pl);
        return {1'b1, 3'(dx), 3'(dy), 3'(dz), 7'h55, pl};
    endfunction

    // expected {err, port} from the requirements
    function automatic logic [7:0] model(int cx, int cy, int cz, int dx, int dy, int dz);
        if (dx >= 2 || dy >= 2 || dz >= 4) return {1'b1, P_LOC};   // R7
        if (cx < dx) return {1'b0, P_E};                              // R1
        if (cx > dx) return {1'b0, P_W};
        if (cy < dy) return {1'b0, P_N};                              // R2
        if (cy > dy) return {1'b0, P_S};
        if (cz < dz) return {1'b0, P_U};                              // R3
        if (cz > dz) return {1'b0, P_D};
        return {1'b0, P_LOC};                                         // R4
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic send_hdr(int cx, int cy, int cz, int dx, int dy, int dz, logic [15:0] pl, string req);
        item_t it;
        logic [7:0] m;
        @(negedge clk);
        cur_x = 3'(cx); cur_y = 3'(cy); cur_z = 3'(cz);
        in_valid = 1'b1;
        in_flit  = hdr(dx, dy, dz, pl);
        m = model(cx, cy, cz, dx, dy, dz);
        it.port = m[6:0];
        it.err  = m[7];
        it.flit = in_flit;
        it.flit[22:16] = m[6:0];
        it.req  = req;
        sbq.push_back(it);
    endtask

    task automatic send_body(logic [32:0] f, logic [6:0] exp_port, string req);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_flit  = f;
        it.port = exp_port; it.flit = f; it.err = 1'b0; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: pops expected items as results appear
    initial begin
        forever begin
            @(posedge clk); #1;
            if (sb_on && out_valid) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R8", "unexpected out_valid", 64'(out_valid), 64'd0);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    check(out_port == it.port, it.req, "out_port", 64'(out_port), 64'(it.port));
                    check(out_flit == it.flit, "R5", "out_flit", 64'(out_flit), 64'(it.flit));
                    check(out_err == it.err, it.req, "out_err", 64'(out_err), 64'(it.err));
                end
            end
        end
    end

    // watchdog
    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check(out_valid == 1'b0, "R9", "reset out_valid", 64'(out_valid), 64'd0);
        check(out_port == 7'd0, "R9", "reset out_port", 64'(out_port), 64'd0);
        check(out_err == 1'b0, "R9", "reset out_err", 64'(out_err), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        sb_on = 1'b1;

        // R9 body before any header gets the cleared latched direction
        send_body({1'b0, 32'h1234_5678}, 7'd0, "R9");
        idle();

        // R1..R4, R5: every source/destination pair inside the mesh
        for (int s = 0; s < 16; s++) begin
            for (int d = 0; d < 16; d++) begin
                send_hdr(s & 1, (s >> 1) & 1, s >> 2, d & 1, (d >> 1) & 1, d >> 2,
                         16'(s * 16 + d), "R1-4");
            end
        end
        idle();

        // R7 destinations outside the mesh
        send_hdr(0, 0, 0, 2, 0, 0, 16'hA001, "R7");
        send_hdr(1, 1, 1, 1, 7, 1, 16'hA002, "R7");
        send_hdr(0, 1, 2, 0, 1, 5, 16'hA003, "R7");
        send_hdr(1, 0, 3, 1, 0, 4, 16'hA004, "R7");
        // R6 body after an out-of-range header keeps LOCAL and err low
        send_body({1'b0, 32'hBEEF_0001}, P_LOC, "R6");

        // R6 body flits hold the header's direction
        send_hdr(1, 0, 0, 0, 0, 0, 16'h0B01, "R1");
        send_body({1'b0, 32'hCAFE_0001}, P_W, "R6");
        send_body({1'b0, 32'hCAFE_0002}, P_W, "R6");
        send_hdr(1, 1, 0, 1, 1, 3, 16'h0B02, "R3");
        send_body({1'b0, 32'hCAFE_0003}, P_U, "R6");

        // R8 idle cycle with stray header data changes nothing
        @(negedge clk);
        in_valid = 1'b0;
        in_flit  = hdr(0, 0, 0, 16'hDEAD);
        cur_x = 3'd1; cur_y = 3'd0; cur_z = 3'd0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check(out_valid == 1'b0, "R8", "idle out_valid", 64'(out_valid), 64'd0);
        send_body({1'b0, 32'hCAFE_0004}, P_U, "R8");
        idle();
        repeat (3) @(posedge clk);
        check(sbq.size() == 0, "R8", "results outstanding", 64'(sbq.size()), 64'd0);
        sb_on = 1'b0;

        // R10 hop-by-hop walk for every pair
        for (int s = 0; s < 16; s++) begin
            for (int d = 0; d < 16; d++) begin
                int cx, cy, cz, dx, dy, dz, hops, phase, axis, manh;
                bit order_ok, done;
                cx = s & 1; cy = (s >> 1) & 1; cz = s >> 2;
                dx = d & 1; dy = (d >> 1) & 1; dz = d >> 2;
                manh = (cx > dx ? cx - dx : dx - cx) + (cy > dy ? cy - dy : dy - cy)
                     + (cz > dz ? cz - dz : dz - cz);
                hops = 0; phase = 0; order_ok = 1'b1; done = 1'b0;
                for (int k = 0; k < 12 && !done; k++) begin
                    @(negedge clk);
                    cur_x = 3'(cx); cur_y = 3'(cy); cur_z = 3'(cz);
                    in_valid = 1'b1;
                    in_flit  = hdr(dx, dy, dz, 16'(k));
                    @(posedge clk); #1;
                    axis = phase;
                    case (out_port)
                        P_LOC: done = 1'b1;
                        P_E: begin cx++; axis = 0; end
                        P_W: begin cx--; axis = 0; end
                        P_N: begin cy++; axis = 1; end
                        P_S: begin cy--; axis = 1; end
                        P_U: begin cz++; axis = 2; end
                        P_D: begin cz--; axis = 2; end
                        default: begin done = 1'b1; order_ok = 1'b0; end
                    endcase
                    if (!done) begin
                        if (axis < phase) order_ok = 1'b0;
                        phase = axis;
                        hops++;
                    end
                end
                check(hops == manh, "R10", "hop count", 64'(hops), 64'(manh));
                check(order_ok, "R10", "dimension order", 64'(order_ok), 64'd1);
                check(cx == dx && cy == dy && cz == dz, "R10", "arrival node",
                      64'(cz * 4 + cy * 2 + cx), 64'(dz * 4 + dy * 2 + dx));
            end
        end
        idle();
        @(posedge clk); #1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule